// File: doc/BRIEF.md
# In-Array Bitwise Logic Memory Subarray

This block is a synthesizable functional model of one memory subarray whose row buffer can compute a bitwise AND or OR of whole rows without moving data out of the array. A small command bus issues row opens, a triple-row open, column reads and writes, and a close. A row address and a column address go with each command. Only the logical effect of each command is modelled. Sensing margins, refresh and timing rules are not modelled.

The row buffer takes the place of the sense amplifiers. Opening a row loads it into the buffer. Opening a second row while the buffer is still sensed copies the buffer into that row. A triple open raises three fixed scratch rows together, through their own small decoder, and the buffer settles to the bitwise majority of the three. That majority is then written back into all three scratch rows. To get A AND B, software copies A and B into two scratch rows and copies the all-zeros row into the third. To get A OR B, it copies the all-ones row into the third instead. Afterwards the result can be read out, or copied into any other row by a further open.

Two rows hold constants: the zeros row and the ones row. These two rows and the three scratch rows are the five highest row indices. With ROWS rows, the scratch rows are ROWS-5, ROWS-4 and ROWS-3, the zeros row is ROWS-2 and the ones row is ROWS-1. With the default 16 rows these are rows 11, 12, 13, 14 and 15. A misused command is dropped and sets a sticky error flag.

Top module: `bulk_logic_subarray`

## Requirements
- R1: After reset, rdValid and errFlag are 0 and no row is open. Row ROWS-2 reads as all zeros and row ROWS-1 reads as all ones.
- R2: cmd code 1 (open) with no row open loads row rowAddr into the row buffer. cmd code 3 (read) with a row open returns buffer bits [c*COL_W +: COL_W] for c = colAddr on rdData, with rdValid high, in the cycle after the command.
- R3: cmd code 4 (write) with a row open replaces column colAddr of the buffer with wrData. The same column is also updated in every row whose wordline is raised, so the change is still there after the row is closed and opened again.
- R4: cmd code 1 (open) while a row is already open writes the current buffer into row rowAddr. The buffer is unchanged and the row stays open. This is the in-array row copy.
- R5: cmd code 2 (triple open) with no row open loads the buffer with the bitwise majority (a&b | a&c | b&c) of scratch rows ROWS-5, ROWS-4 and ROWS-3. The same majority is written into all three scratch rows. rowAddr is ignored.
- R6: When one scratch row holds a copy of row ROWS-2, the triple open yields the AND of the other two scratch rows. When it holds a copy of row ROWS-1, it yields their OR.
- R7: A triple open while a row is open, or a read or write while no row is open, changes neither the buffer nor any row and produces no rdValid. It sets errFlag, which then stays 1 until reset.
- R8: cmd code 5 (close) closes the row. The next open (code 1) loads rather than copies, and a read issued after a close gives no rdValid. Codes 0, 6 and 7 do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd | input | 3 | Command: 0 none, 1 open, 2 triple open, 3 read, 4 write, 5 close |
| rowAddr | input | ROW_AW | Row for an open command |
| colAddr | input | COL_AW | Column word for read or write |
| wrData | input | COL_W | Write data |
| rdData | output | COL_W | Read data, valid with rdValid |
| rdValid | output | 1 | High in the cycle after a legal read |
| errFlag | output | 1 | Sticky flag for an illegal command |

## Verification
On every cycle, the assertions check the command legality rules. A legal read is always followed by rdValid and an illegal one never is. An illegal command always sets the error flag, the flag never clears, and a close always leaves the subarray idle. Whether the data itself is right can only be shown by the bench's scenarios: the majority, AND and OR results, write-back into all three scratch rows, row copies, and the survival of writes across a close. The bench checks these by reading rows back through the column port and comparing them with its own row model.

// File: rtl/bulk_logic_pkg.sv
package bulk_logic_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_TRI = 3'd2,
    CMD_RD  = 3'd3,
    CMD_WR  = 3'd4,
    CMD_PRE = 3'd5
  } cmdE;

  typedef struct packed {
    logic loadRow;
    logic copyRow;
    logic triple;
    logic read;
    logic write;
    logic close;
  } strobeT;
endpackage

// File: rtl/bulk_logic_ctrl.sv
module bulk_logic_ctrl
  import bulk_logic_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] cmd,
  output strobeT     st,
  output logic       rowOpen,
  output logic       errFlag
);
  logic badCmd;

  always_comb begin
    st     = '0;
    badCmd = 1'b0;
    case (cmdE'(cmd))
      CMD_ACT: if (rowOpen) st.copyRow = 1'b1; else st.loadRow = 1'b1;
      CMD_TRI: if (rowOpen) badCmd = 1'b1; else st.triple = 1'b1;
      CMD_RD:  if (rowOpen) st.read = 1'b1; else badCmd = 1'b1;
      CMD_WR:  if (rowOpen) st.write = 1'b1; else badCmd = 1'b1;
      CMD_PRE: st.close = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rowOpen <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      if (st.loadRow || st.triple) rowOpen <= 1'b1;
      else if (st.close)           rowOpen <= 1'b0;
      if (badCmd) errFlag <= 1'b1;
    end
  end
endmodule

// File: rtl/bulk_logic_datapath.sv
module bulk_logic_datapath
  import bulk_logic_pkg::*;
#(
  parameter int ROWS  = 16,
  parameter int ROW_W = 64,
  parameter int COL_W = 8,
  localparam int ROW_AW = $clog2(ROWS),
  localparam int COLS   = ROW_W / COL_W,
  localparam int COL_AW = (COLS > 1) ? $clog2(COLS) : 1
)(
  input  logic              clk,
  input  logic              rst,
  input  strobeT            st,
  input  logic [ROW_AW-1:0] rowSel,
  input  logic [COL_AW-1:0] colSel,
  input  logic [COL_W-1:0]  wrData,
  output logic [COL_W-1:0]  rdData,
  output logic              rdValid
);
  localparam int SCR0 = ROWS - 5;
  localparam int SCR1 = ROWS - 4;
  localparam int SCR2 = ROWS - 3;
  localparam int ONES = ROWS - 1;
  localparam logic [ROWS-1:0] SCRATCH_MASK =
    (ROWS'(1) << SCR0) | (ROWS'(1) << SCR1) | (ROWS'(1) << SCR2);

  logic [ROW_W-1:0] cells [ROWS];
  logic [ROW_W-1:0] rowBuf;
  logic [ROWS-1:0]  raised;
  logic [ROW_W-1:0] majority;

  function automatic logic [ROW_W-1:0] putCol(input logic [ROW_W-1:0] row,
                                              input logic [COL_AW-1:0] idx,
                                              input logic [COL_W-1:0] word);
    logic [ROW_W-1:0] r;
    r = row;
    r[idx*COL_W +: COL_W] = word;
    return r;
  endfunction

  assign majority = (cells[SCR0] & cells[SCR1]) |
                    (cells[SCR0] & cells[SCR2]) |
                    (cells[SCR1] & cells[SCR2]);

  always_ff @(posedge clk) begin
    for (int r = 0; r < ROWS; r++) begin
      if (rst)
        cells[r] <= (r == ONES) ? '1 : '0;
      else if (st.copyRow && rowSel == ROW_AW'(r))
        cells[r] <= rowBuf;
      else if (st.triple && SCRATCH_MASK[r])
        cells[r] <= majority;
      else if (st.write && raised[r])
        cells[r] <= putCol(cells[r], colSel, wrData);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rowBuf  <= '0;
      raised  <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= st.read;
      if (st.read) rdData <= rowBuf[colSel*COL_W +: COL_W];
      if (st.loadRow) begin
        rowBuf <= cells[rowSel];
        raised <= ROWS'(1) << rowSel;
      end else if (st.copyRow) begin
        raised <= raised | (ROWS'(1) << rowSel);
      end else if (st.triple) begin
        rowBuf <= majority;
        raised <= SCRATCH_MASK;
      end else if (st.write) begin
        rowBuf <= putCol(rowBuf, colSel, wrData);
      end else if (st.close) begin
        raised <= '0;
      end
    end
  end
endmodule

// File: rtl/bulk_logic_subarray.sv
module bulk_logic_subarray
  import bulk_logic_pkg::*;
#(
  parameter int ROWS  = 16,
  parameter int ROW_W = 64,
  parameter int COL_W = 8,
  localparam int ROW_AW = $clog2(ROWS),
  localparam int COLS   = ROW_W / COL_W,
  localparam int COL_AW = (COLS > 1) ? $clog2(COLS) : 1
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cmd,
  input  logic [ROW_AW-1:0] rowAddr,
  input  logic [COL_AW-1:0] colAddr,
  input  logic [COL_W-1:0]  wrData,
  output logic [COL_W-1:0]  rdData,
  output logic              rdValid,
  output logic              errFlag
);
  strobeT st;
  logic   rowOpen;

  bulk_logic_ctrl u_ctrl (
    .clk(clk), .rst(rst), .cmd(cmd), .st(st), .rowOpen(rowOpen), .errFlag(errFlag)
  );

  bulk_logic_datapath #(.ROWS(ROWS), .ROW_W(ROW_W), .COL_W(COL_W)) u_dp (
    .clk(clk), .rst(rst), .st(st), .rowSel(rowAddr), .colSel(colAddr),
    .wrData(wrData), .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: rtl/bulk_logic_checker.sv
module bulk_logic_checker
  import bulk_logic_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic [2:0] cmd,
  input logic       rowOpen,
  input logic       rdValid,
  input logic       errFlag
);
  a_r2_read_answers: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_RD && rowOpen) |=> rdValid);

  a_r2_valid_only_after_read: assert property (@(posedge clk) disable iff (rst)
    rdValid |-> ($past(cmd) == CMD_RD && $past(rowOpen)));

  a_r7_idle_read_rejected: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_RD && !rowOpen) |=> (!rdValid && errFlag));

  a_r7_triple_when_open: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_TRI && rowOpen) |=> (errFlag && rowOpen));

  a_r7_idle_write_rejected: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_WR && !rowOpen) |=> (errFlag && !rowOpen));

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
    errFlag |=> errFlag);

  a_r8_close_idles: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_PRE) |=> !rowOpen);

  a_r5_triple_opens: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_TRI && !rowOpen) |=> rowOpen);
endmodule

bind bulk_logic_subarray bulk_logic_checker u_chk (
  .clk(clk), .rst(rst), .cmd(cmd), .rowOpen(rowOpen), .rdValid(rdValid), .errFlag(errFlag)
);

// File: tb/tb_bulk_logic_subarray.sv
`timescale 1ns/1ps
module tb_bulk_logic_subarray;
  localparam int ROWS = 16, ROW_W = 64, COL_W = 8, COLS = ROW_W / COL_W;
  localparam int S0 = ROWS - 5, S1 = ROWS - 4, S2 = ROWS - 3, ZR = ROWS - 2, OR1 = ROWS - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic [2:0] cmd = 3'd0;
  logic [3:0] rowAddr = '0;
  logic [2:0] colAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic rdValid, errFlag;

  int checks = 0, errors = 0;
  logic [ROW_W-1:0] model [ROWS];

  always #2.5 clk = ~clk;

  bulk_logic_subarray dut (
    .clk(clk), .rst(rst), .cmd(cmd), .rowAddr(rowAddr), .colAddr(colAddr),
    .wrData(wrData), .rdData(rdData), .rdValid(rdValid), .errFlag(errFlag)
  );

  function automatic logic [ROW_W-1:0] maj3(input logic [ROW_W-1:0] a, b, c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic [ROW_W-1:0] rand64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [ROW_W-1:0] act, input logic [ROW_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] c, input int row, input int col, input logic [7:0] d);
    @(negedge clk);
    cmd = c; rowAddr = 4'(row); colAddr = 3'(col); wrData = d;
    @(negedge clk);
    cmd = 3'd0;
  endtask

  task automatic writeRow(input int row, input logic [ROW_W-1:0] data);
    issue(3'd1, row, 0, 0);
    for (int c = 0; c < COLS; c++) issue(3'd4, 0, c, data[c*COL_W +: COL_W]);
    issue(3'd5, 0, 0, 0);
    model[row] = data;
  endtask

  task automatic checkOpen(input logic [ROW_W-1:0] exp, input string req);
    for (int c = 0; c < COLS; c++) begin
      issue(3'd3, 0, c, 0);
      check(rdValid === 1'b1 && rdData === exp[c*COL_W +: COL_W], req, "column word",
            {55'd0, rdValid, rdData}, {56'd1, exp[c*COL_W +: COL_W]});
    end
  endtask

  task automatic checkRow(input int row, input string req);
    issue(3'd1, row, 0, 0);
    checkOpen(model[row], req);
    issue(3'd5, 0, 0, 0);
  endtask

  task automatic copyRow(input int src, input int dst);
    issue(3'd1, src, 0, 0);
    issue(3'd1, dst, 0, 0);
    issue(3'd5, 0, 0, 0);
    model[dst] = model[src];
  endtask

  task automatic bitOp(input bit useOr, input string req);
    logic [ROW_W-1:0] a, b, res;
    a = rand64(); b = rand64();
    writeRow(2, a); writeRow(3, b);
    copyRow(2, S0); copyRow(3, S1); copyRow(useOr ? OR1 : ZR, S2);
    res = useOr ? (a | b) : (a & b);
    issue(3'd2, 0, 0, 0);
    checkOpen(res, req);
    issue(3'd1, 6, 0, 0);          // copy the result out (R4)
    issue(3'd5, 0, 0, 0);
    model[6] = res; model[S0] = res; model[S1] = res; model[S2] = res;
    checkRow(6, "R4");
    checkRow(S0, "R5"); checkRow(S1, "R5"); checkRow(S2, "R5");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL all: watchdog actual hung expected finished");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [ROW_W-1:0] a, b, c, keep;
    void'($urandom(32'd2024));
    for (int r = 0; r < ROWS; r++) model[r] = (r == OR1) ? '1 : '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(rdValid === 1'b0 && errFlag === 1'b0, "R1", "reset outputs",
          {62'd0, rdValid, errFlag}, 64'd0);
    checkRow(ZR, "R1");
    checkRow(OR1, "R1");

    // R2 R3: random fill of ordinary rows and readback
    for (int r = 0; r < S0; r++) writeRow(r, rand64());
    for (int r = 0; r < S0; r++) checkRow(r, "R3");

    // R4: plain row copy
    copyRow(7, 9);
    checkRow(9, "R4");
    checkRow(7, "R4");

    // R5 R6: AND and OR, mixed random
    for (int i = 0; i < 6; i++) bitOp(i[0], i[0] ? "R6_or" : "R6_and");

    // R5: general majority of three random scratch rows
    a = rand64(); b = rand64(); c = rand64();
    writeRow(S0, a); writeRow(S1, b); writeRow(S2, c);
    issue(3'd2, 9, 0, 0);
    checkOpen(maj3(a, b, c), "R5");
    issue(3'd5, 0, 0, 0);
    model[S0] = maj3(a, b, c); model[S1] = model[S0]; model[S2] = model[S0];
    checkRow(S2, "R5");
    checkRow(9, "R5");

    // R8: NOP codes do nothing and close turns next open into a load
    issue(3'd6, 0, 0, 0);
    issue(3'd7, 0, 0, 0);
    issue(3'd0, 0, 0, 0);
    check(rdValid === 1'b0 && errFlag === 1'b0, "R8", "unused codes",
          {62'd0, rdValid, errFlag}, 64'd0);
    issue(3'd1, 0, 0, 0);
    issue(3'd5, 0, 0, 0);
    checkRow(1, "R8");

    // R7: illegal read
    issue(3'd3, 0, 2, 0);
    check(rdValid === 1'b0 && errFlag === 1'b1, "R7", "idle read",
          {62'd0, rdValid, errFlag}, 64'd1);
    // R7: illegal write leaves row 4 intact
    issue(3'd4, 0, 3, 8'hA5);
    checkRow(4, "R7");
    // R7: triple while open leaves buffer and scratch rows
    keep = model[5];
    issue(3'd1, 5, 0, 0);
    issue(3'd2, 0, 0, 0);
    checkOpen(keep, "R7");
    issue(3'd5, 0, 0, 0);
    checkRow(S0, "R7");
    // R8: read after close gives no data
    issue(3'd3, 0, 0, 0);
    check(rdValid === 1'b0, "R8", "read after close", {63'd0, rdValid}, 64'd0);
    repeat (5) issue(3'd0, 0, 0, 0);
    check(errFlag === 1'b1, "R7", "sticky flag", {63'd0, errFlag}, 64'd1);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule